// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a serial stereo PCM stream into parallel sample words. Its inputs are a bit clock, a word clock that toggles once per channel word, and a serial data line. Each rising edge of the bit clock samples one data bit. A format select chosen at run time sets three things: the framing (I2S, left-justified or right-justified), the bit order (MSB-first or LSB-first) and the word width (16, 18, 20 or 24 bits). Slots outside the chosen width are discarded, and each captured word is sign-extended to 24 bits.

The serial side runs on the bit clock. When a left/right pair is complete, the block holds it in registers and flips a toggle. A three-flop synchronizer carries that toggle into the system clock domain. There the block loads the pair into its output registers and raises a valid strobe for one cycle. The format inputs are meant to change only while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: `wsel_i` selects the word width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24.
- R2: With `framing_i` = 0 (I2S), a low word clock marks the left channel. The first data bit is sampled on the second rising bit-clock edge after the word clock changes.
- R3: With `framing_i` = 1 (left-justified), a high word clock marks the left channel. The first data bit is sampled on the rising bit-clock edge that first sees the new word-clock level.
- R4: With `framing_i` = 2 or 3 (right-justified), a high word clock marks the left channel. The last bit of the word is the final slot before the next word-clock change.
- R5: With `lsb_first_i` = 0 the first data bit of a word is its MSB. With `lsb_first_i` = 1 the first data bit is its LSB.
- R6: Data bits in slots outside the selected width do not affect the delivered words.
- R7: Every delivered word is the received word sign-extended from bit width-1 to 24 bits.
- R8: Each stereo pair (a left word followed by a right word) raises `valid_o` for exactly one system clock cycle. This happens after the word-clock change that ends the right word. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R9: After reset `valid_o`, `left_o` and `right_o` are zero. A word that was already in progress when the first word-clock change is seen is discarded. No pair is delivered until a complete left word has been received.
- R10: The serial data line is sampled on the rising edge of the bit clock. It may change freely while the bit clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (left/right select) |
| sdata_i | input | 1 | Serial audio data |
| framing_i | input | 2 | 0 = I2S, 1 = left-justified, 2 or 3 = right-justified |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| wsel_i | input | 2 | Word width select (16/18/20/24) |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
Each of the 24 combinations of framing, bit order and width carries four frames of random samples. Random garbage bits fill every unused slot, so a window that is one slot off or a wrong alignment corrupts the received words. Because the samples are random, roughly half of them have the sign bit set, which checks the extension at each width. Every group starts from reset with the word clock idling at the right-channel level. This checks that a partial first word is discarded. It also checks that each pair appears only when the next word clock change arrives.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int WLEN_W   = $clog2(SAMPLE_W + 1);

    localparam logic [1:0] FR_I2S  = 2'd0;
    localparam logic [1:0] FR_LEFT = 2'd1;

    function automatic logic [WLEN_W-1:0] width_of(input logic [1:0] sel);
        case (sel)
            2'd0:    width_of = WLEN_W'(16);
            2'd1:    width_of = WLEN_W'(18);
            2'd2:    width_of = WLEN_W'(20);
            default: width_of = WLEN_W'(24);
        endcase
    endfunction

endpackage

// File: rtl/sarx_deser.sv
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int SW    = SAMPLE_W,
    parameter int CNT_W = 6
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          wclk_i,
    input  logic          sdata_i,
    input  logic [1:0]    framing_i,
    input  logic          lsb_first_i,
    input  logic [1:0]    wsel_i,
    output logic [SW-1:0] pair_l_o,
    output logic [SW-1:0] pair_r_o,
    output logic          tgl_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             wclk;
        logic [CNT_W-1:0] cnt;
        logic [SW-1:0]    sr;
        logic             armed;
        logic             have_left;
        logic [SW-1:0]    left_hold;
        logic [SW-1:0]    pair_l;
        logic [SW-1:0]    pair_r;
        logic             tgl;
    } deser_t;

    deser_t st_d, st_q;

    logic              edge_c;
    logic              is_rj;
    logic [CNT_W-1:0]  off;
    logic [CNT_W-1:0]  slot;
    logic [WLEN_W-1:0] wlen;
    logic [WLEN_W-1:0] shamt;
    logic              in_win;
    logic [SW-1:0]     base;
    logic [SW-1:0]     shifted;
    logic [SW-1:0]     word;
    logic              done_left;

    always_comb begin
        st_d   = st_q;
        edge_c = (wclk_i != st_q.wclk);
        is_rj  = framing_i[1];
        off    = (framing_i == FR_I2S) ? CNT_W'(1) : CNT_W'(0);
        wlen   = width_of(wsel_i);
        shamt  = WLEN_W'(SW) - wlen;

        if (edge_c)                slot = '0;
        else if (st_q.cnt == CNT_MAX) slot = st_q.cnt;
        else                       slot = st_q.cnt + CNT_W'(1);

        in_win = is_rj || ((slot >= off) && ((slot - off) < CNT_W'(wlen)));

        base    = edge_c ? '0 : st_q.sr;
        shifted = lsb_first_i ? {sdata_i, base[SW-1:1]} : {base[SW-2:0], sdata_i};

        if (lsb_first_i) word = SW'($signed(st_q.sr) >>> shamt);
        else             word = SW'($signed(st_q.sr << shamt) >>> shamt);

        done_left = (framing_i == FR_I2S) ? !st_q.wclk : st_q.wclk;

        st_d.wclk = wclk_i;
        st_d.cnt  = slot;
        st_d.sr   = in_win ? shifted : base;

        if (edge_c) begin
            st_d.armed = 1'b1;
            if (st_q.armed) begin
                if (done_left) begin
                    st_d.left_hold = word;
                    st_d.have_left = 1'b1;
                end else if (st_q.have_left) begin
                    st_d.pair_l    = st_q.left_hold;
                    st_d.pair_r    = word;
                    st_d.tgl       = ~st_q.tgl;
                    st_d.have_left = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_l_o = st_q.pair_l;
    assign pair_r_o = st_q.pair_r;
    assign tgl_o    = st_q.tgl;

    // R6: past the last possible data slot, framed modes stop shifting
    p_ignore_tail_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (!is_rj && !edge_c && st_q.cnt >= CNT_W'(SW + 1)) |=> (edge_c || $stable(st_q.sr)));

    // R9: the first word-clock change only arms; nothing is handed over
    p_no_pair_unarmed_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (edge_c && !st_q.armed) |=> $stable(st_q.tgl));

    // R8: a pair is only released once a left word has been held
    p_left_before_right_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        !$stable(st_q.tgl) |-> $past(st_q.have_left));

endmodule

// File: rtl/sarx_handoff.sv
module sarx_handoff
    import sarx_pkg::*;
#(
    parameter int SW     = SAMPLE_W,
    parameter int SYNC_N = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tgl_i,
    input  logic [SW-1:0] pair_l_i,
    input  logic [SW-1:0] pair_r_i,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o,
    output logic          valid_o
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic [SW-1:0]     left;
        logic [SW-1:0]     right;
        logic              valid;
    } hand_t;

    hand_t st_d, st_q;
    logic  pulse;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], tgl_i};
        pulse     = st_q.sync[SYNC_N-1] ^ st_q.sync[SYNC_N-2];
        st_d.valid = pulse;
        if (pulse) begin
            st_d.left  = pair_l_i;
            st_d.right = pair_r_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign valid_o = st_q.valid;

    // R8: the strobe lasts a single cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: outputs only move together with the strobe
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SW     = SAMPLE_W,
    parameter int CNT_W  = 6,
    parameter int SYNC_N = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          wclk_i,
    input  logic          sdata_i,
    input  logic [1:0]    framing_i,
    input  logic          lsb_first_i,
    input  logic [1:0]    wsel_i,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o,
    output logic          valid_o
);

    logic [SW-1:0] pair_l;
    logic [SW-1:0] pair_r;
    logic          tgl;

    sarx_deser #(.SW(SW), .CNT_W(CNT_W)) u_deser (
        .sclk        (sclk_i),
        .rst_n       (rst_n),
        .wclk_i      (wclk_i),
        .sdata_i     (sdata_i),
        .framing_i   (framing_i),
        .lsb_first_i (lsb_first_i),
        .wsel_i      (wsel_i),
        .pair_l_o    (pair_l),
        .pair_r_o    (pair_r),
        .tgl_o       (tgl)
    );

    sarx_handoff #(.SW(SW), .SYNC_N(SYNC_N)) u_handoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgl_i    (tgl),
        .pair_l_i (pair_l),
        .pair_r_i (pair_r),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        wclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [1:0]  framing_i = 2'd0;
    logic        lsb_first_i = 1'b0;
    logic [1:0]  wsel_i = 2'd0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [23:0] exp_l[$];
    logic [23:0] exp_r[$];
    string tag = "R2";

    always #10 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .wclk_i(wclk_i),
        .sdata_i(sdata_i), .framing_i(framing_i), .lsb_first_i(lsb_first_i),
        .wsel_i(wsel_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    function automatic int wbits(input logic [1:0] s);
        case (s)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] v, input int w);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

    // reference: compare every system clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            tests++;
            if (exp_l.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected pair: got %h/%h expected none", left_o, right_o);
            end else begin
                logic [23:0] el, er;
                el = exp_l.pop_front();
                er = exp_r.pop_front();
                if (left_o !== el || right_o !== er) begin
                    fails++;
                    $display("FAIL %s R1 R5 R6 R7 R10 fr=%0d lsb=%0d w=%0d: got %h/%h expected %h/%h",
                             tag, framing_i, lsb_first_i, wbits(wsel_i), left_o, right_o, el, er);
                end
            end
        end
    end

    task automatic slot(input logic lvl, input logic bitv);
        wclk_i  = lvl;
        sdata_i = bitv;
        #80 sclk_i = 1'b1;
        #80 sclk_i = 1'b0;
    endtask

    task automatic send_word(input logic lvl, input logic [23:0] v, input int w);
        for (int s = 0; s < 32; s++) begin
            int p;
            if (framing_i == 2'd0)      p = s - 1;
            else if (framing_i == 2'd1) p = s;
            else                        p = s - (32 - w);
            if (p >= 0 && p < w) slot(lvl, lsb_first_i ? v[p] : v[w-1-p]);
            else                 slot(lvl, 1'($urandom % 2));
        end
    endtask

    task automatic run_group(input logic [1:0] fr, input logic lsb, input logic [1:0] ws);
        logic lvl_l;
        int w;
        rst_n = 1'b0;
        framing_i = fr; lsb_first_i = lsb; wsel_i = ws;
        tag = (fr == 2'd0) ? "R2" : (fr == 2'd1) ? "R3" : "R4";
        w = wbits(ws);
        lvl_l = (fr == 2'd0) ? 1'b0 : 1'b1;
        wclk_i = 1'b0;
        #100;
        @(negedge clk);
        tests++;
        if (valid_o !== 1'b0 || left_o !== 24'd0 || right_o !== 24'd0) begin
            fails++;
            $display("FAIL R9 reset state: got v=%b l=%h r=%h expected 0/0/0", valid_o, left_o, right_o);
        end
        rst_n = 1'b1;
        #100;
        for (int i = 0; i < 6; i++) slot(!lvl_l, 1'($urandom % 2));
        for (int f = 0; f < 4; f++) begin
            logic [23:0] l, r;
            l = 24'($urandom);
            r = 24'($urandom);
            exp_l.push_back(sext(l, w));
            exp_r.push_back(sext(r, w));
            send_word(lvl_l, l, w);
            send_word(!lvl_l, r, w);
        end
        for (int i = 0; i < 4; i++) slot(lvl_l, 1'($urandom % 2));
        #1000;
        tests++;
        if (exp_l.size() != 0) begin
            fails++;
            $display("FAIL R8 %s pairs missing: got %0d left over expected 0", tag, exp_l.size());
            exp_l.delete();
            exp_r.delete();
        end
    endtask

    initial begin
        for (int fr = 0; fr < 3; fr++)
            for (int lb = 0; lb < 2; lb++)
                for (int ws = 0; ws < 4; ws++)
                    run_group(2'(fr), 1'(lb), 2'(ws));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #3ms;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule